// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Nibble Flags

This block is the arithmetic stage of an accumulator-style CPU core. Each operation takes the accumulator, a second operand and the current flag byte. It produces a result byte, a write strobe for the accumulator, a new flag byte and the number of machine cycles the instruction costs. The operations are add, add with carry, subtract, subtract with borrow, compare, increment and decrement. The four flags are zero, subtract, half-carry and carry.

Instruction decode, memory access, the register file and any 16-bit pointer arithmetic sit outside this block. The core presents an operation together with a strobe. The block registers the outcome on that clock edge and holds it until the next strobe. A single shared adder chain, split into nibble slices, serves every operation. Subtraction inverts the operand and the carry, and the half-carry comes from the boundary between the lowest slice and the one above it.

Top module: `alu8_core`

## Requirements
- R1: For operation codes 0 to 6, flag bit 7 (zero) is set exactly when the registered 8-bit wrapped result is 0x00.
- R2: Flag bit 6 (subtract) is set by SUB (2), SBC (3), CMP (4) and DEC (6), and it is cleared by ADD (0), ADC (1) and INC (5).
- R3: For ADD, ADC and INC, flag bit 5 (half-carry) is set when the two low nibbles plus the carry-in sum to 0x10 or more. The carry-in is flag bit 4 of `flags_i` for ADC and 0 otherwise. INC adds the constant 1.
- R4: For SUB, SBC, CMP and DEC, flag bit 5 is set when the low nibble of the accumulator is less than the low nibble of the operand plus the borrow-in. The borrow-in is flag bit 4 of `flags_i` for SBC and 0 otherwise. DEC subtracts the constant 1.
- R5: For ADD, ADC, SUB, SBC and CMP, flag bit 4 (carry) is the carry out of bit 7 (for the additions) or the borrow (for the subtractions), with the incoming carry included for ADC and SBC. The result is the wrapped 8-bit sum or difference.
- R6: INC and DEC act on the accumulator and ignore `opnd_i`. They copy flag bit 4 of `flags_i` unchanged into the new flags.
- R7: CMP computes the difference and sets the flags like SUB, but it never raises `acc_we_o`. The other operation codes from 0 to 6 raise `acc_we_o` for the cycle after their strobe.
- R8: `cycles_o` is 4 for a register operand (`src_mem_i`=0) and 8 for a memory operand (`src_mem_i`=1).
- R9: The flag byte is packed as Z in bit 7, N in bit 6, H in bit 5 and C in bit 4, and bits 3..0 always read as zero.
- R10: Outputs update only on a clock edge where `valid_i` is high. While `valid_i` is low, the result and flags hold and `acc_we_o` is 0.
- R11: A synchronous active-low reset clears the result, the flags, `acc_we_o` and `cycles_o` to zero.
- R12: Operation code 7 (HOLD) writes nothing. It sets the result to the accumulator and passes flag bits 7..4 of `flags_i` through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Strobe: register this operation's outcome |
| op_i | input | 3 | Operation code (0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 CMP, 5 INC, 6 DEC, 7 HOLD) |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand |
| flags_i | input | 8 | Current flag byte |
| src_mem_i | input | 1 | Operand came from memory through the pointer pair |
| result_o | output | 8 | Registered result byte |
| acc_we_o | output | 1 | Accumulator write strobe |
| flags_o | output | 8 | Registered new flag byte |
| cycles_o | output | 4 | Instruction cycle count |

## Verification
The bench builds the block with its default parameters: an 8-bit data path split into two 4-bit slices, with 4 and 8 cycle costs. With this split, the half-carry is taken from the carry between the two slices, so inputs such as 0x0F plus 1, 0x10 minus 1 and a zero low nibble with a borrow-in reach that boundary directly. The eight-bit width also lets random operands hit full wrap-around to zero and the borrow out of 0x00 often. The stimulus mixes random operation codes, operands and carry-ins with these edges.

// File: rtl/alu8_pkg.sv
// Shared types for the accumulator ALU.
// Assumes an 8-bit flag byte with the four flags in the upper nibble.
package alu8_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADC  = 3'd1,
        OP_SUB  = 3'd2,
        OP_SBC  = 3'd3,
        OP_CMP  = 3'd4,
        OP_INC  = 3'd5,
        OP_DEC  = 3'd6,
        OP_HOLD = 3'd7
    } alu_op_e;

    localparam int FLAG_W     = 8;
    localparam int FLAG_Z_BIT = 7;
    localparam int FLAG_N_BIT = 6;
    localparam int FLAG_H_BIT = 5;
    localparam int FLAG_C_BIT = 4;

    typedef struct packed {
        logic       z;
        logic       n;
        logic       h;
        logic       c;
        logic [3:0] zero_lo;
    } alu_flags_t;

endpackage

// File: rtl/alu8_nibble_add.sv
// One slice of the ALU adder chain: W-bit add with carry in and out.
// Assumes nothing beyond the operands being plain unsigned values.
module alu8_nibble_add #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    // Slice sum including the chained carry.
    assign {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};

endmodule

// File: rtl/alu8_ctrl.sv
// Operation decoder: turns an operation code and the incoming carry into
// adder controls and flag policy.
// Assumes subtraction is done as A + ~B + ~borrow on the shared adder.
module alu8_ctrl
    import alu8_pkg::*;
(
    input  alu_op_e op_i,
    input  logic    carry_i,
    output logic    use_one_o,
    output logic    invert_o,
    output logic    cin_o,
    output logic    write_o,
    output logic    n_flag_o,
    output logic    keep_c_o,
    output logic    hold_o
);

    // Per-operation control table.
    always_comb begin
        use_one_o = 1'b0;
        invert_o  = 1'b0;
        cin_o     = 1'b0;
        write_o   = 1'b1;
        n_flag_o  = 1'b0;
        keep_c_o  = 1'b0;
        hold_o    = 1'b0;
        unique case (op_i)
            OP_ADD: ;
            OP_ADC: cin_o = carry_i;
            OP_SUB: begin
                invert_o = 1'b1;
                cin_o    = 1'b1;
                n_flag_o = 1'b1;
            end
            OP_SBC: begin
                invert_o = 1'b1;
                cin_o    = ~carry_i;
                n_flag_o = 1'b1;
            end
            OP_CMP: begin
                invert_o = 1'b1;
                cin_o    = 1'b1;
                n_flag_o = 1'b1;
                write_o  = 1'b0;
            end
            OP_INC: begin
                use_one_o = 1'b1;
                keep_c_o  = 1'b1;
            end
            OP_DEC: begin
                use_one_o = 1'b1;
                invert_o  = 1'b1;
                cin_o     = 1'b1;
                n_flag_o  = 1'b1;
                keep_c_o  = 1'b1;
            end
            OP_HOLD: begin
                write_o = 1'b0;
                hold_o  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu8_datapath.sv
// Shared adder chain built from nibble slices. Reports the carry out of
// the lowest slice (half) and out of the top slice (full), both already
// turned into borrows when the operand is inverted.
// Assumes DATA_W is a whole multiple of NIB_W.
module alu8_datapath #(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              invert_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              half_o,
    output logic              full_o
);

    localparam int NUM_SL = DATA_W / NIB_W;

    logic [DATA_W-1:0] b_eff;
    logic [NUM_SL:0]   carry;

    // Operand inversion for subtract-type operations.
    assign b_eff    = b_i ^ {DATA_W{invert_i}};
    assign carry[0] = cin_i;

    for (genvar g = 0; g < NUM_SL; g++) begin : g_slice
        alu8_nibble_add #(.W(NIB_W)) u_slice (
            .a_i    (a_i[g*NIB_W +: NIB_W]),
            .b_i    (b_eff[g*NIB_W +: NIB_W]),
            .cin_i  (carry[g]),
            .sum_o  (sum_o[g*NIB_W +: NIB_W]),
            .cout_o (carry[g+1])
        );
    end

    // A missing carry in subtract mode is a borrow.
    assign half_o = carry[1] ^ invert_i;
    assign full_o = carry[NUM_SL] ^ invert_i;

endmodule

// File: rtl/alu8_core.sv
// Top of the accumulator ALU: decodes the operation, runs the shared
// adder chain, builds the flag byte and registers everything on a
// valid strobe.
// Assumes the caller holds inputs stable around the strobed clock edge.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int NIB_W      = 4,
    parameter int CYC_W      = 4,
    parameter int REG_CYCLES = 4,
    parameter int MEM_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [7:0]        flags_i,
    input  logic              src_mem_i,
    output logic [DATA_W-1:0] result_o,
    output logic              acc_we_o,
    output logic [7:0]        flags_o,
    output logic [CYC_W-1:0]  cycles_o
);

    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    alu_op_e           op;
    logic              use_one, invert, cin, write, n_flag, keep_c, hold;
    logic [DATA_W-1:0] operand, sum;
    logic              half, full;
    alu_flags_t        nxt_flags;
    logic [DATA_W-1:0] nxt_result;
    logic [CYC_W-1:0]  nxt_cycles;
    logic              unused_flag_lo;

    assign op             = alu_op_e'(op_i);
    assign unused_flag_lo = ^flags_i[3:0];

    alu8_ctrl u_ctrl (
        .op_i      (op),
        .carry_i   (flags_i[FLAG_C_BIT]),
        .use_one_o (use_one),
        .invert_o  (invert),
        .cin_o     (cin),
        .write_o   (write),
        .n_flag_o  (n_flag),
        .keep_c_o  (keep_c),
        .hold_o    (hold)
    );

    // Select the constant one for increment and decrement.
    assign operand = use_one ? ONE : opnd_i;

    alu8_datapath #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_dp (
        .a_i      (acc_i),
        .b_i      (operand),
        .invert_i (invert),
        .cin_i    (cin),
        .sum_o    (sum),
        .half_o   (half),
        .full_o   (full)
    );

    // Assemble the next result, flag byte and cycle cost.
    always_comb begin
        nxt_flags.zero_lo = 4'b0000;
        if (hold) begin
            nxt_result  = acc_i;
            nxt_flags.z = flags_i[FLAG_Z_BIT];
            nxt_flags.n = flags_i[FLAG_N_BIT];
            nxt_flags.h = flags_i[FLAG_H_BIT];
            nxt_flags.c = flags_i[FLAG_C_BIT];
        end else begin
            nxt_result  = sum;
            nxt_flags.z = (sum == '0);
            nxt_flags.n = n_flag;
            nxt_flags.h = half;
            nxt_flags.c = keep_c ? flags_i[FLAG_C_BIT] : full;
        end
        nxt_cycles = src_mem_i ? CYC_W'(MEM_CYCLES) : CYC_W'(REG_CYCLES);
    end

    // Output registers, loaded only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            flags_o  <= '0;
            acc_we_o <= 1'b0;
            cycles_o <= '0;
        end else begin
            acc_we_o <= valid_i & write;
            if (valid_i) begin
                result_o <= nxt_result;
                flags_o  <= nxt_flags;
                cycles_o <= nxt_cycles;
            end
        end
    end

endmodule

// File: rtl/alu8_core_chk.sv
// Property checker for alu8_core, attached through bind.
// Assumes the port names of alu8_core.
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CYC_W      = 4,
    parameter int REG_CYCLES = 4,
    parameter int MEM_CYCLES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic [2:0]        op_i,
    input logic [7:0]        flags_i,
    input logic              src_mem_i,
    input logic [DATA_W-1:0] result_o,
    input logic              acc_we_o,
    input logic [7:0]        flags_o,
    input logic [CYC_W-1:0]  cycles_o
);

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(result_o) && $stable(flags_o) && !acc_we_o);

    // R7
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_CMP) |=> !acc_we_o);

    // R6
    keep_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (op_i == OP_INC || op_i == OP_DEC))
        |=> flags_o[FLAG_C_BIT] == $past(flags_i[FLAG_C_BIT]));

    // R2
    sub_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (op_i == OP_SUB || op_i == OP_SBC || op_i == OP_CMP || op_i == OP_DEC))
        |=> flags_o[FLAG_N_BIT]);

    // R1
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i != OP_HOLD) |=> flags_o[FLAG_Z_BIT] == (result_o == '0));

    // R8
    cycle_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> cycles_o == ($past(src_mem_i) ? CYC_W'(MEM_CYCLES) : CYC_W'(REG_CYCLES)));

    // R9
    flag_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> flags_o[3:0] == 4'b0000);

endmodule

bind alu8_core alu8_core_chk #(
    .DATA_W     (DATA_W),
    .CYC_W      (CYC_W),
    .REG_CYCLES (REG_CYCLES),
    .MEM_CYCLES (MEM_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .op_i      (op_i),
    .flags_i   (flags_i),
    .src_mem_i (src_mem_i),
    .result_o  (result_o),
    .acc_we_o  (acc_we_o),
    .flags_o   (flags_o),
    .cycles_o  (cycles_o)
);

// File: tb/tb_alu8_core.sv
// Self-checking bench for alu8_core: directed corners plus seeded random.
module tb_alu8_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid_i = 1'b0;
    logic [2:0] op_i = 3'd0;
    logic [7:0] acc_i = 8'h00;
    logic [7:0] opnd_i = 8'h00;
    logic [7:0] flags_i = 8'h00;
    logic       src_mem_i = 1'b0;
    logic [7:0] result_o;
    logic       acc_we_o;
    logic [7:0] flags_o;
    logic [3:0] cycles_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    alu8_core dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (valid_i),
        .op_i      (op_i),
        .acc_i     (acc_i),
        .opnd_i    (opnd_i),
        .flags_i   (flags_i),
        .src_mem_i (src_mem_i),
        .result_o  (result_o),
        .acc_we_o  (acc_we_o),
        .flags_o   (flags_o),
        .cycles_o  (cycles_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model: returns {we, result[7:0], flags[7:0]}.
    function automatic logic [16:0] model(input int op, input int a, input int b, input int f);
        int  cin, r, lo;
        bit  z, n, h, c, we;
        cin = (f >> 4) & 1;
        c   = (f >> 4) & 1;
        we  = 1;
        n   = 0;
        h   = 0;
        r   = 0;
        case (op)
            0: begin r = a + b; h = ((a & 15) + (b & 15)) > 15; c = r > 255; end
            1: begin r = a + b + cin; h = ((a & 15) + (b & 15) + cin) > 15; c = r > 255; end
            2, 4: begin
                r = a - b; h = (a & 15) < (b & 15); c = a < b; n = 1;
                if (op == 4) we = 0;
            end
            3: begin r = a - b - cin; h = (a & 15) < ((b & 15) + cin); c = a < (b + cin); n = 1; end
            5: begin r = a + 1; h = (a & 15) == 15; end
            6: begin r = a - 1; h = (a & 15) == 0; n = 1; end
            default: begin
                we = 0;
                return {1'b0, a[7:0], f[7:4], 4'b0000};
            end
        endcase
        lo = r & 255;
        z  = (lo == 0);
        return {we, lo[7:0], z, n, h, c, 4'b0000};
    endfunction

    task automatic run_vec(input int op, input int a, input int b, input int f, input bit mem);
        logic [16:0] e;
        string       rt, ht, ct;
        e = model(op, a, b, f);
        @(negedge clk);
        op_i = op[2:0]; acc_i = a[7:0]; opnd_i = b[7:0]; flags_i = f[7:0]; src_mem_i = mem;
        valid_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        valid_i = 1'b0;
        if (op == 7) begin
            check("R12 hold result", int'(result_o), int'(e[15:8]));
            check("R12 hold flags", int'(flags_o), int'(e[7:0]));
            check("R12 hold no write", int'(acc_we_o), 0);
        end else begin
            rt = (op == 4) ? "R7 compare result" : (op >= 5) ? "R6 inc/dec result" : "R5 result";
            ht = (op == 0 || op == 1 || op == 5) ? "R3 add half-carry" : "R4 sub half-carry";
            ct = (op >= 5) ? "R6 kept carry" : "R5 carry";
            check(rt, int'(result_o), int'(e[15:8]));
            check("R7 write strobe", int'(acc_we_o), int'(e[16]));
            check("R1 zero", int'(flags_o[7]), int'(e[7]));
            check("R2 subtract", int'(flags_o[6]), int'(e[6]));
            check(ht, int'(flags_o[5]), int'(e[5]));
            check(ct, int'(flags_o[4]), int'(e[4]));
            check("R9 low flag bits", int'(flags_o[3:0]), 0);
        end
        check("R8 cycle cost", int'(cycles_o), mem ? 8 : 4);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] keep_r, keep_f;
        void'($urandom(32'h5EED_A1B2));
        // R11 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 reset result", int'(result_o), 0);
        check("R11 reset flags", int'(flags_o), 0);
        check("R11 reset strobe", int'(acc_we_o), 0);
        check("R11 reset cycles", int'(cycles_o), 0);
        rst_n = 1'b1;

        // Directed corners
        run_vec(0, 8'h0F, 8'h01, 8'h00, 0);
        run_vec(0, 8'hFF, 8'h01, 8'h00, 1);
        run_vec(1, 8'h0E, 8'h01, 8'h10, 0);
        run_vec(1, 8'hFF, 8'h00, 8'h10, 0);
        run_vec(2, 8'h10, 8'h01, 8'h00, 0);
        run_vec(2, 8'h05, 8'h05, 8'h10, 1);
        run_vec(3, 8'h00, 8'h00, 8'h10, 0);
        run_vec(3, 8'h20, 8'h1F, 8'h10, 0);
        run_vec(4, 8'h42, 8'h42, 8'h00, 1);
        run_vec(4, 8'h10, 8'h20, 8'h00, 0);
        run_vec(5, 8'hFF, 8'h33, 8'h00, 0);
        run_vec(5, 8'h0F, 8'hAA, 8'h10, 0);
        run_vec(6, 8'h01, 8'h77, 8'h10, 0);
        run_vec(6, 8'h00, 8'h00, 8'h00, 1);
        run_vec(7, 8'h3C, 8'h99, 8'hAF, 0);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            run_vec(int'($urandom_range(0, 7)), int'($urandom_range(0, 255)),
                    int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                    1'($urandom_range(0, 1)));
        end

        // R10 hold while strobe is low
        run_vec(0, 8'h12, 8'h34, 8'h00, 1);
        keep_r = result_o;
        keep_f = flags_o;
        @(negedge clk);
        op_i = 3'd2; acc_i = 8'h00; opnd_i = 8'h01; flags_i = 8'hF0; src_mem_i = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 idle result", int'(result_o), int'(keep_r));
        check("R10 idle flags", int'(flags_o), int'(keep_f));
        check("R10 idle strobe", int'(acc_we_o), 0);
        check("R10 idle cycles", int'(cycles_o), 8);

        // R11 reset after activity
        run_vec(2, 8'h00, 8'h01, 8'h00, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 mid reset result", int'(result_o), 0);
        check("R11 mid reset flags", int'(flags_o), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule